// File: doc/BRIEF.md
# Warp-Serializing SIMD Lane Sequencer

This block runs one 32-thread warp instruction on a cluster of eight 32-bit integer lanes. The lanes run on a fast clock at twice the rate of the issue logic. The 2:1 ratio is modelled with a single fast clock and a core-clock enable, `core_en`, that the surrounding logic raises on every other fast cycle. The issue logic offers at most one instruction per core cycle. An instruction carries an opcode, three source operand indices, a destination index and a 32-bit mask of active threads. The sequencer accepts the instruction only on an enabled cycle.

After acceptance the warp is swept through the lanes as four groups of eight threads, one group per fast cycle. During each sweep cycle the block drives the current group number and the latched source indices. The register storage outside the block returns the three operand vectors for that group in the same cycle. The lanes compute the result and the block drives it on an eight-wide write-back bus, with a lane-enable vector taken from the active mask. Inactive threads still occupy their lane slot, but their write-back is suppressed. Busy covers the four sweep cycles. A one-cycle done pulse follows the last group. A new instruction may be accepted during the last group, so that back-to-back instructions keep the lanes fully occupied.

Top module: `warp_lane_seq`

## Requirements
- R1: During reset and in the first cycle after it, `busy`, `done` and `wb_valid` are low and `wb_lane_en` is all zero.
- R2: `issue_ready` is high only when `core_en` is high and the sequencer is either idle or sweeping its last group. An instruction is taken only when `issue_valid` and `issue_ready` are both high at a clock edge. An offer made while `core_en` is low starts nothing.
- R3: In the four fast cycles after acceptance, `wb_valid` is high and `wb_group` counts 0, 1, 2, 3. During those cycles `fetch_ra`, `fetch_rb`, `fetch_rc` and `wb_rd` equal the indices given at acceptance.
- R4: `busy` is high in exactly the four sweep cycles of an instruction and is low once the sweep ends with no new acceptance.
- R5: `done` is high for exactly one fast cycle: the cycle right after group 3 was on the bus.
- R6: In group g, lane l handles thread 8*g+l. Its operands are slice l (bits 32*l+31 down to 32*l) of `opnd_a`, `opnd_b` and `opnd_c`, and its result appears in the same slice of `wb_data`.
- R7: Opcode 0 gives a+b, 1 gives a-b, 2 gives the low 32 bits of a*b, and 3 gives the low 32 bits of a*b+c, all modulo 2^32.
- R8: `wb_lane_en[l]` equals mask bit 8*g+l during group g, and a disabled lane drives zero on its `wb_data` slice. An all-zero mask is still swept for four cycles.
- R9: An instruction accepted during group 3 starts its group 0 in the next cycle. In that cycle `busy` stays high and the previous instruction's `done` pulse is also present.
- R10: Changes to the issue inputs after acceptance have no effect on the sweep in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast lane clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_en | input | 1 | Core-clock enable, high on every other fast cycle |
| issue_valid | input | 1 | Issue logic offers an instruction |
| issue_ready | output | 1 | Offer will be taken at this edge |
| issue_op | input | 2 | Opcode (0 add, 1 sub, 2 mul, 3 multiply-add) |
| issue_ra | input | 6 | Source A index |
| issue_rb | input | 6 | Source B index |
| issue_rc | input | 6 | Source C index |
| issue_rd | input | 6 | Destination index |
| issue_mask | input | 32 | Active-thread mask, bit t for thread t |
| fetch_ra | output | 6 | Source A index for the current group |
| fetch_rb | output | 6 | Source B index for the current group |
| fetch_rc | output | 6 | Source C index for the current group |
| opnd_a | input | 256 | Eight A operands of the current group |
| opnd_b | input | 256 | Eight B operands of the current group |
| opnd_c | input | 256 | Eight C operands of the current group |
| wb_valid | output | 1 | A group is on the write-back bus |
| wb_group | output | 2 | Group number, also used for operand fetch |
| wb_rd | output | 6 | Destination index |
| wb_lane_en | output | 8 | Per-lane write enable from the mask |
| wb_data | output | 256 | Eight lane results |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is an acceptance during the last group. It needs an offer at the one cycle in four where `core_en` is high and the group counter sits at 3. In that cycle the old sweep's done pulse overlaps the new sweep's first group. The bench tracks the parity of `core_en` from a known start and places the second offer on exactly that cycle for every opcode. It also offers garbage fields during the early groups, where `core_en` is high but the sequencer is not ready, to show that they are dropped.

// File: rtl/wls_pkg.sv
package wls_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_MUL = 2'd2,
        OP_MAD = 2'd3
    } lane_op_e;

endpackage

// File: rtl/wls_lane.sv
module wls_lane
    import wls_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            en_i,
    input  lane_op_e        op_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic [XLEN-1:0] c_i,
    output logic [XLEN-1:0] res_o
);

    logic [XLEN-1:0] prod;
    logic [XLEN-1:0] raw;

    always_comb begin
        prod = a_i * b_i;
        unique case (op_i)
            OP_ADD:  raw = a_i + b_i;
            OP_SUB:  raw = a_i - b_i;
            OP_MUL:  raw = prod;
            OP_MAD:  raw = prod + c_i;
            default: raw = '0;
        endcase
        res_o = en_i ? raw : '0;
    end

endmodule

// File: rtl/wls_seq.sv
module wls_seq
    import wls_pkg::*;
#(
    parameter int WARP  = 32,
    parameter int LANES = 8,
    parameter int RAW   = 6,
    localparam int GROUPS = WARP / LANES,
    localparam int GW     = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             core_en_i,
    input  logic             issue_valid_i,
    output logic             issue_ready_o,
    input  logic [1:0]       issue_op_i,
    input  logic [RAW-1:0]   issue_ra_i,
    input  logic [RAW-1:0]   issue_rb_i,
    input  logic [RAW-1:0]   issue_rc_i,
    input  logic [RAW-1:0]   issue_rd_i,
    input  logic [WARP-1:0]  issue_mask_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [GW-1:0]    grp_o,
    output lane_op_e         op_o,
    output logic [RAW-1:0]   ra_o,
    output logic [RAW-1:0]   rb_o,
    output logic [RAW-1:0]   rc_o,
    output logic [RAW-1:0]   rd_o,
    output logic [LANES-1:0] lane_en_o
);

    localparam logic [GW-1:0] LAST_GRP = GW'(GROUPS - 1);

    typedef struct packed {
        logic            busy;
        logic            done;
        logic [GW-1:0]   grp;
        lane_op_e        op;
        logic [RAW-1:0]  ra;
        logic [RAW-1:0]  rb;
        logic [RAW-1:0]  rc;
        logic [RAW-1:0]  rd;
        logic [WARP-1:0] mask;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic    last_grp;
    logic    accept;

    always_comb begin
        last_grp      = st_q.busy && (st_q.grp == LAST_GRP);
        issue_ready_o = core_en_i && (!st_q.busy || last_grp);
        accept        = issue_valid_i && issue_ready_o;

        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            if (last_grp) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.grp  = '0;
            end else begin
                st_d.grp = st_q.grp + GW'(1);
            end
        end
        if (accept) begin
            st_d.busy = 1'b1;
            st_d.grp  = '0;
            st_d.op   = lane_op_e'(issue_op_i);
            st_d.ra   = issue_ra_i;
            st_d.rb   = issue_rb_i;
            st_d.rc   = issue_rc_i;
            st_d.rd   = issue_rd_i;
            st_d.mask = issue_mask_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, done: 1'b0, grp: '0, op: OP_ADD,
                      ra: '0, rb: '0, rc: '0, rd: '0, mask: '0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        busy_o    = st_q.busy;
        done_o    = st_q.done;
        grp_o     = st_q.grp;
        op_o      = st_q.op;
        ra_o      = st_q.ra;
        rb_o      = st_q.rb;
        rc_o      = st_q.rc;
        rd_o      = st_q.rd;
        lane_en_o = st_q.busy ? st_q.mask[st_q.grp*LANES +: LANES] : '0;
    end

    AST_ACCEPT_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid_i && issue_ready_o) |-> core_en_i); // R2
    AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid_i && issue_ready_o) |=> (busy_o && grp_o == '0)); // R3
    AST_GROUP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && grp_o != LAST_GRP) |=> (busy_o && grp_o == $past(grp_o) + GW'(1))); // R3
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && grp_o == LAST_GRP) |=> done_o); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R5
    AST_IDLE_AFTER_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && grp_o == LAST_GRP && !issue_valid_i) |=> !busy_o); // R4
    AST_HOLD_DURING_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && grp_o != LAST_GRP) |=> $stable(ra_o) && $stable(rd_o)); // R10

endmodule

// File: rtl/warp_lane_seq.sv
module warp_lane_seq
    import wls_pkg::*;
#(
    parameter int WARP  = 32,
    parameter int LANES = 8,
    parameter int XLEN  = 32,
    parameter int RAW   = 6,
    localparam int GROUPS = WARP / LANES,
    localparam int GW     = (GROUPS > 1) ? $clog2(GROUPS) : 1,
    localparam int BUSW   = LANES * XLEN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             core_en,
    input  logic             issue_valid,
    output logic             issue_ready,
    input  logic [1:0]       issue_op,
    input  logic [RAW-1:0]   issue_ra,
    input  logic [RAW-1:0]   issue_rb,
    input  logic [RAW-1:0]   issue_rc,
    input  logic [RAW-1:0]   issue_rd,
    input  logic [WARP-1:0]  issue_mask,
    output logic [RAW-1:0]   fetch_ra,
    output logic [RAW-1:0]   fetch_rb,
    output logic [RAW-1:0]   fetch_rc,
    input  logic [BUSW-1:0]  opnd_a,
    input  logic [BUSW-1:0]  opnd_b,
    input  logic [BUSW-1:0]  opnd_c,
    output logic             wb_valid,
    output logic [GW-1:0]    wb_group,
    output logic [RAW-1:0]   wb_rd,
    output logic [LANES-1:0] wb_lane_en,
    output logic [BUSW-1:0]  wb_data,
    output logic             busy,
    output logic             done
);

    lane_op_e         cur_op;
    logic [LANES-1:0] lane_en;
    logic             seq_busy;

    wls_seq #(
        .WARP (WARP),
        .LANES(LANES),
        .RAW  (RAW)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .core_en_i    (core_en),
        .issue_valid_i(issue_valid),
        .issue_ready_o(issue_ready),
        .issue_op_i   (issue_op),
        .issue_ra_i   (issue_ra),
        .issue_rb_i   (issue_rb),
        .issue_rc_i   (issue_rc),
        .issue_rd_i   (issue_rd),
        .issue_mask_i (issue_mask),
        .busy_o       (seq_busy),
        .done_o       (done),
        .grp_o        (wb_group),
        .op_o         (cur_op),
        .ra_o         (fetch_ra),
        .rb_o         (fetch_rb),
        .rc_o         (fetch_rc),
        .rd_o         (wb_rd),
        .lane_en_o    (lane_en)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        wls_lane #(.XLEN(XLEN)) u_lane (
            .en_i (lane_en[l]),
            .op_i (cur_op),
            .a_i  (opnd_a[l*XLEN +: XLEN]),
            .b_i  (opnd_b[l*XLEN +: XLEN]),
            .c_i  (opnd_c[l*XLEN +: XLEN]),
            .res_o(wb_data[l*XLEN +: XLEN])
        );
    end

    always_comb begin
        busy       = seq_busy;
        wb_valid   = seq_busy;
        wb_lane_en = lane_en;
    end

    AST_NO_WB_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_valid |-> (wb_data == '0)); // R8
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done)); // R1

endmodule

// File: tb/warp_lane_seq_bench.sv
module warp_lane_seq_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         core_en = 1'b0;
    logic         issue_valid = 1'b0;
    logic         issue_ready;
    logic [1:0]   issue_op = '0;
    logic [5:0]   issue_ra = '0, issue_rb = '0, issue_rc = '0, issue_rd = '0;
    logic [31:0]  issue_mask = '0;
    logic [5:0]   fetch_ra, fetch_rb, fetch_rc;
    logic [255:0] opnd_a, opnd_b, opnd_c;
    logic         wb_valid;
    logic [1:0]   wb_group;
    logic [5:0]   wb_rd;
    logic [7:0]   wb_lane_en;
    logic [255:0] wb_data;
    logic         busy, done;

    int n_cmp = 0;
    int n_bad = 0;

    warp_lane_seq u_warp_lane_seq (
        .clk(clk), .rst_n(rst_n), .core_en(core_en),
        .issue_valid(issue_valid), .issue_ready(issue_ready),
        .issue_op(issue_op), .issue_ra(issue_ra), .issue_rb(issue_rb),
        .issue_rc(issue_rc), .issue_rd(issue_rd), .issue_mask(issue_mask),
        .fetch_ra(fetch_ra), .fetch_rb(fetch_rb), .fetch_rc(fetch_rc),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c),
        .wb_valid(wb_valid), .wb_group(wb_group), .wb_rd(wb_rd),
        .wb_lane_en(wb_lane_en), .wb_data(wb_data),
        .busy(busy), .done(done)
    );

    always #4 clk = ~clk;
    always @(negedge clk) core_en <= ~core_en;

    function automatic logic [31:0] regval(input logic [5:0] idx, input int thread);
        return ((32'(idx) * 32'h0101_0405) ^ (32'(thread) * 32'h9E37_79B9)) + 32'h0000_0011;
    endfunction

    function automatic logic [31:0] expect_res(input logic [1:0] op, input logic [31:0] a,
                                               input logic [31:0] b, input logic [31:0] c);
        case (op)
            2'd0:    return a + b;
            2'd1:    return a - b;
            2'd2:    return a * b;
            default: return a * b + c;
        endcase
    endfunction

    always_comb begin
        for (int l = 0; l < 8; l++) begin
            opnd_a[l*32 +: 32] = regval(fetch_ra, int'(wb_group) * 8 + l);
            opnd_b[l*32 +: 32] = regval(fetch_rb, int'(wb_group) * 8 + l);
            opnd_c[l*32 +: 32] = regval(fetch_rc, int'(wb_group) * 8 + l);
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_core(input logic v);
        while (core_en !== v) step();
    endtask

    task automatic drive(input logic [1:0] op, input logic [5:0] ra, rb, rc, rd,
                         input logic [31:0] mask);
        issue_valid = 1'b1;
        issue_op = op; issue_ra = ra; issue_rb = rb; issue_rc = rc; issue_rd = rd;
        issue_mask = mask;
    endtask

    task automatic chk_group(input int g, input logic [1:0] op, input logic [5:0] ra, rb, rc, rd,
                             input logic [31:0] mask);
        check(wb_valid === 1'b1, "R3", "wb_valid", 32'(wb_valid), 1);
        check(wb_group === 2'(g), "R3", "wb_group", 32'(wb_group), 32'(g));
        check(busy === 1'b1, "R4", "busy in sweep", 32'(busy), 1);
        check(fetch_ra === ra && fetch_rb === rb && fetch_rc === rc, "R3", "fetch idx",
              {14'd0, fetch_ra, fetch_rb, fetch_rc}, {14'd0, ra, rb, rc});
        check(wb_rd === rd, "R10", "wb_rd held", 32'(wb_rd), 32'(rd));
        for (int l = 0; l < 8; l++) begin
            automatic int t = g * 8 + l;
            automatic logic en = mask[t];
            automatic logic [31:0] e = en ? expect_res(op, regval(ra, t), regval(rb, t), regval(rc, t)) : 32'd0;
            check(wb_lane_en[l] === en, "R8", "lane enable", 32'(wb_lane_en[l]), 32'(en));
            check(wb_data[l*32 +: 32] === e, en ? "R7" : "R8", "lane data (R6 slice)",
                  wb_data[l*32 +: 32], e);
        end
    endtask

    // Single instruction, with garbage offered during the early groups (R10, R2).
    task automatic run_one(input logic [1:0] op, input logic [5:0] ra, rb, rc, rd,
                           input logic [31:0] mask);
        wait_core(1'b1);
        drive(op, ra, rb, rc, rd, mask);
        check(issue_ready === 1'b1, "R2", "ready when idle", 32'(issue_ready), 1);
        step();
        drive(~op, ~ra, ~rb, ~rc, ~rd, ~mask);
        chk_group(0, op, ra, rb, rc, rd, mask);
        step();
        check(issue_ready === 1'b0, "R2", "ready mid sweep", 32'(issue_ready), 0);
        chk_group(1, op, ra, rb, rc, rd, mask);
        step();
        chk_group(2, op, ra, rb, rc, rd, mask);
        issue_valid = 1'b0;
        step();
        chk_group(3, op, ra, rb, rc, rd, mask);
        step();
        check(done === 1'b1, "R5", "done pulse", 32'(done), 1);
        check(busy === 1'b0, "R4", "busy after sweep", 32'(busy), 0);
        check(wb_valid === 1'b0, "R4", "wb_valid after sweep", 32'(wb_valid), 0);
        step();
        check(done === 1'b0, "R5", "done single cycle", 32'(done), 0);
    endtask

    // Two instructions back to back: second accepted during group 3 (R9).
    task automatic run_pair(input logic [1:0] op, input logic [31:0] m1, input logic [31:0] m2);
        wait_core(1'b1);
        drive(op, 6'd3, 6'd17, 6'd40, 6'd9, m1);
        step();
        issue_valid = 1'b0;
        chk_group(0, op, 6'd3, 6'd17, 6'd40, 6'd9, m1);
        step(); chk_group(1, op, 6'd3, 6'd17, 6'd40, 6'd9, m1);
        step(); chk_group(2, op, 6'd3, 6'd17, 6'd40, 6'd9, m1);
        step(); chk_group(3, op, 6'd3, 6'd17, 6'd40, 6'd9, m1);
        drive(op ^ 2'd1, 6'd55, 6'd2, 6'd63, 6'd30, m2);
        check(issue_ready === 1'b1, "R9", "ready in last group", 32'(issue_ready), 1);
        step();
        issue_valid = 1'b0;
        check(done === 1'b1, "R9", "done overlaps new sweep", 32'(done), 1);
        chk_group(0, op ^ 2'd1, 6'd55, 6'd2, 6'd63, 6'd30, m2);
        for (int g = 1; g < 4; g++) begin
            step();
            chk_group(g, op ^ 2'd1, 6'd55, 6'd2, 6'd63, 6'd30, m2);
        end
        step();
        check(done === 1'b1 && busy === 1'b0, "R5", "second done", {30'd0, done, busy}, 32'd2);
        step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] masks[5];
        masks[0] = 32'hFFFF_FFFF;
        masks[1] = 32'h0000_0000;
        masks[2] = 32'hA5A5_5A5A;
        masks[3] = 32'h8000_0001;
        masks[4] = 32'h00FF_0F00;

        repeat (3) step();
        check(busy === 1'b0 && done === 1'b0 && wb_valid === 1'b0 && wb_lane_en === 8'h00,
              "R1", "in reset", {29'd0, busy, done, wb_valid}, 0);
        rst_n = 1'b1;
        step();
        check(busy === 1'b0 && done === 1'b0 && wb_valid === 1'b0 && wb_lane_en === 8'h00,
              "R1", "after reset", {29'd0, busy, done, wb_valid}, 0);

        // Offer while the core enable is low: must not start (R2).
        wait_core(1'b0);
        drive(2'd0, 6'd1, 6'd2, 6'd3, 6'd4, 32'hFFFF_FFFF);
        check(issue_ready === 1'b0, "R2", "ready without core_en", 32'(issue_ready), 0);
        step();
        issue_valid = 1'b0;
        check(busy === 1'b0, "R2", "no start without core_en", 32'(busy), 0);
        step();
        check(busy === 1'b0, "R2", "still idle", 32'(busy), 0);

        for (int op = 0; op < 4; op++) begin
            for (int m = 0; m < 5; m++) begin
                run_one(2'(op), 6'(op * 7 + m), 6'(m * 11 + 5), 6'(63 - op - m), 6'(op + m * 4),
                        masks[m]);
            end
        end

        for (int op = 0; op < 4; op++) begin
            run_pair(2'(op), masks[op], masks[(op + 2) % 5]);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule